// File: doc/BRIEF.md
# Embedded Video Sync Code Decoder

The block watches a 10-bit parallel video sample stream, one sample per cycle in which the clock-enable is high. It looks for embedded timing codes: three fixed words followed by a status word. When it sees one, it decodes three flags from the status word: the field, vertical blanking, and whether the code starts or ends active video. It checks these flags against the four protection bits carried in the same word.

Codes that pass the check update the registered field and blanking outputs and raise a one-cycle start or end pulse. Codes that fail raise a one-cycle error pulse and change nothing else. Between a start code outside vertical blanking and the next end code, each enabled picture sample is presented on the output with a valid strobe. Code words and reserved sample values are never presented.

The two least significant data bits are ignored wherever a code is matched, so a source that is only 8 bits wide and justified to the top of the bus works unchanged.

Top module: `vid_trs_decoder`

## Requirements
- R1: Reset (rst_ni low) drives field_o, vblank_o, sav_o, eav_o, prot_err_o and act_valid_o to 0 and forgets any partially matched code, so a status word right after reset is not decoded.
- R2: A code is three enabled words with data_i[9:2] equal to 8'hFF, 8'h00 and 8'h00, followed by an enabled status word. Bits [1:0] of all four words are ignored, and any other middle word breaks the match.
- R3: A word with data_i[9:2]=8'hFF, seen where a zero word was expected, restarts the match as if it were the first word of a code.
- R4: Cycles with en_i low neither advance nor break a partial match, and produce no valid strobe.
- R5: In the status word, bit 9 must be 1. Bits [8:6] are F, V and H, and bits [5:2] are P3..P0, which must equal the table value for {F,V,H}: 000→0000, 001→1101, 010→1011, 011→0110, 100→0111, 101→1010, 110→1100, 111→0001. If either check fails, prot_err_o is 1 for the cycle after the status word, and no SAV/EAV pulse or flag change follows.
- R6: After a code that passes, field_o takes F and vblank_o takes V in the cycle following the status word. Between codes, both outputs hold their values.
- R7: After a code that passes, sav_o (H=0) or eav_o (H=1) is 1 for exactly the cycle following the status word.
- R8: act_valid_o is 1 in the cycle after an enabled sample, and act_data_o then carries that sample, only when the sample follows a passing start code with V=0 and precedes the next passing end code. A start code with V=1 closes the active region.
- R9: act_valid_o is never 1 for a status word or for any sample whose bits [9:2] are all ones or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Sample qualifier |
| data_i | input | 10 | Video sample |
| field_o | output | 1 | Current field (0 = field 1, 1 = field 2) |
| vblank_o | output | 1 | Vertical blanking flag |
| sav_o | output | 1 | Start-of-active pulse |
| eav_o | output | 1 | End-of-active pulse |
| prot_err_o | output | 1 | Protection check failure pulse |
| act_valid_o | output | 1 | Active picture sample strobe |
| act_data_o | output | 10 | Active picture sample |

## Verification
The hardest cases to reach from the ports are a partial match that survives disabled cycles and overlapping restarts in the middle of a code. Another is a corrupted end code inside an active line, which must leave the active region open. The stimulus builds these sequences word by word. It inserts en_i-low gaps with junk data between the preamble words, and repeats an all-ones word in the second and third positions. It sends an end code with a flipped protection bit between two picture samples, then checks that the samples that follow are still passed through. All eight valid status words are also sent in turn to cover the full protection table.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [1:0] {
    MS_IDLE,
    MS_ONE,
    MS_TWO,
    MS_THREE
  } match_st_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
    logic ok;
  } trs_status_t;

  // protection bits P3..P0 derived from F,V,H
  function automatic logic [3:0] trs_prot(input logic f, input logic v, input logic h);
    return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/trs_preamble_match.sv
module trs_preamble_match
  import trs_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              slot_o,
  output logic              reserved_o
);
  localparam int IGN_W = DATA_W - 8;

  match_st_e st_q, st_d;
  logic      ones, zero;

  assign ones = &data_i[DATA_W-1:IGN_W];
  assign zero = ~|data_i[DATA_W-1:IGN_W];
  assign reserved_o = ones | zero;
  assign slot_o = (st_q == MS_THREE);

  always_comb begin
    case (st_q)
      MS_ONE:  st_d = zero ? MS_TWO   : (ones ? MS_ONE : MS_IDLE);
      MS_TWO:  st_d = zero ? MS_THREE : (ones ? MS_ONE : MS_IDLE);
      default: st_d = ones ? MS_ONE : MS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_q <= MS_IDLE;
    else if (en_i) st_q <= st_d;
  end
endmodule

// File: rtl/trs_status_decode.sv
module trs_status_decode
  import trs_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] data_i,
  output trs_status_t       st_o
);
  localparam int MK = DATA_W - 1;
  localparam int PB = DATA_W - 5;

  logic [3:0] prot_rx;

  assign prot_rx = data_i[PB -: 4];
  assign st_o.f  = data_i[MK-1];
  assign st_o.v  = data_i[MK-2];
  assign st_o.h  = data_i[MK-3];
  assign st_o.ok = data_i[MK] & (prot_rx == trs_prot(st_o.f, st_o.v, st_o.h));
endmodule

// File: rtl/trs_active_gate.sv
module trs_active_gate
  import trs_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              slot_i,
  input  logic              reserved_i,
  input  trs_status_t       st_i,
  output logic              field_o,
  output logic              vblank_o,
  output logic              sav_o,
  output logic              eav_o,
  output logic              err_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic hit, good, bad, active_q, take;

  assign hit  = en_i & slot_i;
  assign good = hit & st_i.ok;
  assign bad  = hit & ~st_i.ok;
  assign take = en_i & active_q & ~slot_i & ~reserved_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_o  <= 1'b0;
      vblank_o <= 1'b0;
      sav_o    <= 1'b0;
      eav_o    <= 1'b0;
      err_o    <= 1'b0;
      active_q <= 1'b0;
      valid_o  <= 1'b0;
      data_o   <= '0;
    end else begin
      sav_o   <= good & ~st_i.h;
      eav_o   <= good & st_i.h;
      err_o   <= bad;
      valid_o <= take;
      if (take) data_o <= data_i;
      if (good) begin
        field_o  <= st_i.f;
        vblank_o <= st_i.v;
        active_q <= ~st_i.h & ~st_i.v;
      end
    end
  end
endmodule

// File: rtl/vid_trs_decoder.sv
module vid_trs_decoder
  import trs_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              field_o,
  output logic              vblank_o,
  output logic              sav_o,
  output logic              eav_o,
  output logic              prot_err_o,
  output logic              act_valid_o,
  output logic [DATA_W-1:0] act_data_o
);
  logic        slot, reserved;
  trs_status_t st;

  trs_preamble_match #(.DATA_W(DATA_W)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .data_i     (data_i),
    .slot_o     (slot),
    .reserved_o (reserved)
  );

  trs_status_decode #(.DATA_W(DATA_W)) u_dec (
    .data_i (data_i),
    .st_o   (st)
  );

  trs_active_gate #(.DATA_W(DATA_W)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .data_i     (data_i),
    .slot_i     (slot),
    .reserved_i (reserved),
    .st_i       (st),
    .field_o    (field_o),
    .vblank_o   (vblank_o),
    .sav_o      (sav_o),
    .eav_o      (eav_o),
    .err_o      (prot_err_o),
    .valid_o    (act_valid_o),
    .data_o     (act_data_o)
  );
endmodule

// File: rtl/trs_decoder_chk.sv
module trs_decoder_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [DATA_W-1:0] data_i,
  input logic              field_o,
  input logic              vblank_o,
  input logic              sav_o,
  input logic              eav_o,
  input logic              prot_err_o,
  input logic              act_valid_o,
  input logic [DATA_W-1:0] act_data_o
);
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sav_o, eav_o, prot_err_o})); // R5

  AST_ERR_HOLDS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_err_o |-> ($stable(field_o) && $stable(vblank_o))); // R5

  AST_FLAGS_ON_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((field_o != $past(field_o)) || (vblank_o != $past(vblank_o))) |-> (sav_o || eav_o)); // R6

  AST_SAV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sav_o |=> !sav_o); // R7

  AST_EAV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav_o |=> !eav_o); // R7

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sav_o || eav_o || prot_err_o) |-> $past(en_i)); // R4

  AST_VALID_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o |-> $past(en_i)); // R4

  AST_VALID_NOT_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o |-> !vblank_o); // R8

  AST_VALID_NOT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o |-> !(sav_o || eav_o || prot_err_o)); // R9

  AST_VALID_NOT_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_o |-> ((|act_data_o[DATA_W-1:DATA_W-8]) && !(&act_data_o[DATA_W-1:DATA_W-8]))); // R9
endmodule

bind vid_trs_decoder trs_decoder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_vid_trs_decoder.sv
`timescale 1ns/1ps
module sim_vid_trs_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [9:0] data_i = '0;
  logic       field_o, vblank_o, sav_o, eav_o, prot_err_o, act_valid_o;
  logic [9:0] act_data_o;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [5:0] flags; // sav,eav,err,field,vblank,valid
    logic [9:0] d;
    string      req;
  } exp_t;
  exp_t q[$];

  logic e_field = 1'b0, e_vb = 1'b0, e_act = 1'b0;

  always #2 clk_i = ~clk_i;

  vid_trs_decoder u0 (.*);

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] stat(input logic f, input logic v, input logic h);
    logic [3:0] p;
    case ({f, v, h})
      3'b000: p = 4'b0000;
      3'b001: p = 4'b1101;
      3'b010: p = 4'b1011;
      3'b011: p = 4'b0110;
      3'b100: p = 4'b0111;
      3'b101: p = 4'b1010;
      3'b110: p = 4'b1100;
      default: p = 4'b0001;
    endcase
    return {1'b1, f, v, h, p, 2'b00};
  endfunction

  // drive one cycle and queue what the outputs must show after the next edge
  task automatic push(input logic [9:0] d, input logic e, input logic s, input logic ea,
                      input logic er, input logic vld, input string req);
    exp_t x;
    @(negedge clk_i);
    data_i = d;
    en_i = e;
    x.flags = {s, ea, er, e_field, e_vb, vld};
    x.d = d;
    x.req = req;
    q.push_back(x);
  endtask

  task automatic smp(input logic [9:0] d, input logic e, input string req);
    logic rsv;
    rsv = (d[9:2] == 8'hFF) || (d[9:2] == 8'h00);
    push(d, e, 1'b0, 1'b0, 1'b0, e && e_act && !rsv, req);
  endtask

  task automatic word(input logic [9:0] d, input logic e, input string req);
    push(d, e, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic stat_word(input logic f, input logic v, input logic h, input int mode,
                           input string req);
    logic [9:0] w;
    w = stat(f, v, h);
    if (mode == 1) w[2] = ~w[2];
    if (mode == 2) w[9] = 1'b0;
    w[1:0] = 2'(f + h + 1);
    if (mode == 0) begin
      e_field = f;
      e_vb = v;
      e_act = !h && !v;
      push(w, 1'b1, !h, h, 1'b0, 1'b0, req);
    end else begin
      push(w, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, req);
    end
  endtask

  task automatic code(input logic f, input logic v, input logic h, input int mode, input string req);
    word(10'h3FC | 10'(v), 1'b1, req);
    word(10'h000 | 10'(h + 1), 1'b1, req);
    word(10'h000, 1'b1, req);
    stat_word(f, v, h, mode, req);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t x;
        logic [5:0] a;
        x = q.pop_front();
        a = {sav_o, eav_o, prot_err_o, field_o, vblank_o, act_valid_o};
        check(a == x.flags, x.req, 16'(a), 16'(x.flags));
        if (x.flags[0]) check(act_data_o == x.d, x.req, 16'(act_data_o), 16'(x.d));
      end
    end
  end

  initial begin
    #800000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check({field_o, vblank_o, sav_o, eav_o, prot_err_o, act_valid_o} == 6'b0, "R1 reset",
          16'({field_o, vblank_o, sav_o, eav_o, prot_err_o, act_valid_o}), 16'h0);
    rst_ni = 1'b1;

    // R8 no valid before any start code
    smp(10'h200, 1'b1, "R8 idle");
    smp(10'h155, 1'b1, "R8 idle");
    // R6/R7 blanking codes, R8 no valid in blanking
    code(1'b0, 1'b1, 1'b0, 0, "R7 blank sav");
    smp(10'h240, 1'b1, "R8 blank line");
    code(1'b0, 1'b1, 1'b1, 0, "R6 blank eav");
    // active line
    code(1'b0, 1'b0, 1'b0, 0, "R7 sav");
    smp(10'h123, 1'b1, "R8 active");
    smp(10'h080, 1'b1, "R8 active");
    smp(10'h3F0, 1'b1, "R8 active");
    smp(10'h3FD, 1'b1, "R9 reserved ones");
    smp(10'h150, 1'b1, "R8 active");
    smp(10'h002, 1'b1, "R9 reserved zeros");
    smp(10'h2AA, 1'b0, "R4 disabled");
    smp(10'h1C4, 1'b1, "R8 active");
    code(1'b0, 1'b0, 1'b1, 0, "R9 eav words");
    smp(10'h1C4, 1'b1, "R8 after eav");
    // R2 field 2 with noisy low bits
    word(10'h3FF, 1'b1, "R2 lsb");
    word(10'h003, 1'b1, "R2 lsb");
    word(10'h001, 1'b1, "R2 lsb");
    stat_word(1'b1, 1'b0, 1'b0, 0, "R2 field2 sav");
    smp(10'h211, 1'b1, "R8 field2");
    // R4 disabled gaps inside preamble
    word(10'h3FC, 1'b1, "R4 gap");
    word(10'h155, 1'b0, "R4 gap");
    word(10'h000, 1'b1, "R4 gap");
    word(10'h2AA, 1'b0, "R4 gap");
    word(10'h000, 1'b1, "R4 gap");
    word(10'h000, 1'b0, "R4 gap");
    stat_word(1'b1, 1'b0, 1'b1, 0, "R4 eav after gaps");
    // R3 overlapping restarts
    word(10'h3FC, 1'b1, "R3 overlap");
    word(10'h3FC, 1'b1, "R3 overlap");
    word(10'h000, 1'b1, "R3 overlap");
    word(10'h000, 1'b1, "R3 overlap");
    stat_word(1'b1, 1'b0, 1'b0, 0, "R3 sav after ff ff");
    smp(10'h300, 1'b1, "R8 active");
    word(10'h3FC, 1'b1, "R3 overlap");
    word(10'h000, 1'b1, "R3 overlap");
    word(10'h3FE, 1'b1, "R3 overlap");
    word(10'h000, 1'b1, "R3 overlap");
    word(10'h000, 1'b1, "R3 overlap");
    stat_word(1'b1, 1'b0, 1'b1, 0, "R3 eav after restart");
    // R5 protection failures
    code(1'b1, 1'b1, 1'b0, 0, "R6 field2 blank");
    code(1'b0, 1'b0, 1'b0, 1, "R5 bad prot");
    code(1'b0, 1'b0, 1'b1, 2, "R5 bad marker");
    code(1'b1, 1'b0, 1'b0, 0, "R7 sav");
    smp(10'h111, 1'b1, "R8 active");
    code(1'b1, 1'b0, 1'b1, 1, "R5 bad eav keeps active");
    smp(10'h222, 1'b1, "R5 still active");
    // R2 broken preamble
    word(10'h3FC, 1'b1, "R2 near miss");
    word(10'h000, 1'b1, "R2 near miss");
    smp(10'h004, 1'b1, "R2 near miss");
    smp(stat(1'b0, 1'b1, 1'b1), 1'b1, "R2 no decode");
    code(1'b1, 1'b0, 1'b1, 0, "R7 eav");
    // R5 full table
    for (int i = 0; i < 8; i++) begin
      code(i[2], i[1], i[0], 0, "R5 table");
      smp(10'h1A0, 1'b1, "R8 table");
    end
    drain();

    // R1 reset clears partial match
    word(10'h3FC, 1'b1, "R1 pre");
    word(10'h000, 1'b1, "R1 pre");
    word(10'h000, 1'b1, "R1 pre");
    drain();
    en_i = 1'b0;
    rst_ni = 1'b0;
    e_field = 1'b0;
    e_vb = 1'b0;
    e_act = 1'b0;
    @(negedge clk_i);
    check({field_o, vblank_o, sav_o, eav_o, prot_err_o, act_valid_o} == 6'b0, "R1 mid reset",
          16'({field_o, vblank_o, sav_o, eav_o, prot_err_o, act_valid_o}), 16'h0);
    rst_ni = 1'b1;
    smp(stat(1'b1, 1'b0, 1'b0), 1'b1, "R1 match cleared");
    smp(10'h200, 1'b1, "R1 match cleared");
    drain();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule